// File: doc/BRIEF.md
# Link Bring-Up and Receive-Lock Recovery Supervisor

This block controls the power-on bring-up of a serial link port. It also watches the link controller's debug words and decides when the link can be used. After reset it waits for the reference clock to settle, then releases the endpoint reset. It waits again so the endpoint can initialise, and only then enables link training. From the moment training is enabled, it expects the link to report up within a bounded time. If that does not happen, it raises a sticky timeout flag.

A link that tries to move to a faster rate can hang in the receiver-lock phase of recovery when the PHY never reports valid receive data. A controller asks for a stall check by pulsing a start input at the moment it begins a rate change. The block waits a fixed number of milliseconds and then samples the state code and the rx-valid bit once. If the port is stuck, the block signals an event and raises the two receive override enables for a fixed number of clock cycles. All millisecond delays are counted in ticks of a prescaler whose cycles-per-millisecond value is a parameter.

Top module: `link_health_ctrl`

## Requirements
- R1: While reset is asserted, every output of the block is low.
- R2: `ep_rst_release` rises only after SETTLE_MS millisecond ticks have been counted since reset, and it then stays high.
- R3: `train_en` rises after a further PERST_MS ticks with `ep_rst_release` high, and it is never high while `ep_rst_release` is low.
- R4: `link_up` equals debug word 1 bit 4 set AND bit 29 clear, as sampled on the previous clock edge. Bit 29 set masks bit 4.
- R5: The state code is debug word 0 bits 5:0, and the upper bits are ignored. The port counts as stuck when that code equals LOCK_CODE (default 0x0D) and `rx_valid` is 0, sampled at the tick that completes CHECK_MS ticks after a start pulse. A stuck result produces a one-cycle `stuck_evt`.
- R6: After a stuck result, `ovrd_rx_data_en` and `ovrd_rx_pll_en` are high together for exactly PULSE_CYC consecutive cycles. They rise in the same cycle as `stuck_evt`.
- R7: If at the check point `rx_valid` is 1, or the state code differs from LOCK_CODE, no event and no override pulse is produced.
- R8: A start pulse that arrives while a check or override pulse is in progress is ignored, so each attempt produces at most one override pulse.
- R9: If `link_up` has not been seen within TIMEOUT_MS ticks after `train_en` rises, `link_timeout` is set and stays set until reset. Once `link_up` has been seen, no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_word0 | input | 32 | Link controller debug word 0 (state code in bits 5:0) |
| dbg_word1 | input | 32 | Link controller debug word 1 (bit 4 up, bit 29 in training) |
| rx_valid | input | 1 | PHY receive-valid indication |
| rate_chg_start | input | 1 | One-cycle pulse marking the start of a rate-change attempt |
| ep_rst_release | output | 1 | High once the endpoint reset may be released |
| train_en | output | 1 | Link training enable |
| link_up | output | 1 | Link usable |
| stuck_evt | output | 1 | One-cycle pulse when a stalled recovery is detected |
| ovrd_rx_data_en | output | 1 | Receive-data enable override |
| ovrd_rx_pll_en | output | 1 | Receive-PLL enable override |
| link_timeout | output | 1 | Sticky link-up timeout flag |

## Verification
The bench drives the up bit together with the in-training bit. A design that tested only the up bit would report the link as usable during training. Several rate-change attempts run against different state codes and rx-valid values, including a word whose upper bits are nonzero while its low six bits hold the lock code. A design that decoded the wrong field would pulse when it should not, or stay silent when it should pulse. A second start is issued in the middle of a pending check; a design that re-armed on it would emit two pulses or stretch the pulse. Both timeout outcomes are run: a missing link must leave the flag set, and an early link must keep it clear for longer than the window.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  localparam int UP_BIT    = 4;
  localparam int TRAIN_BIT = 29;
  localparam int STATE_W   = 6;

  typedef enum logic [1:0] {
    BU_SETTLE = 2'd0,
    BU_PERST  = 2'd1,
    BU_TRAIN  = 2'd2
  } bu_state_e;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'd0,
    RC_WAIT  = 2'd1,
    RC_PULSE = 2'd2
  } rc_state_e;
endpackage

// File: rtl/lhm_tick.sv
module lhm_tick #(
  parameter int CYC_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lhm_bringup.sv
module lhm_bringup
  import lhm_pkg::*;
#(
  parameter int SETTLE_MS  = 30,
  parameter int PERST_MS   = 20,
  parameter int TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic link_up,
  output logic ep_rst_release,
  output logic train_en,
  output logic link_timeout
);
  localparam int MAXMS = (SETTLE_MS > PERST_MS) ? SETTLE_MS : PERST_MS;
  localparam int MW = $clog2(MAXMS + 1);
  localparam int TW = $clog2(TIMEOUT_MS + 1);
  localparam logic [MW-1:0] SETTLE_LAST = MW'(SETTLE_MS - 1);
  localparam logic [MW-1:0] PERST_LAST  = MW'(PERST_MS - 1);
  localparam logic [TW-1:0] TO_LAST     = TW'(TIMEOUT_MS - 1);

  bu_state_e st_q, st_d;
  logic [MW-1:0] ms_q, ms_d;
  logic [TW-1:0] tc_q, tc_d;
  logic seen_q, seen_d;
  logic to_q, to_d;

  always_comb begin
    st_d   = st_q;
    ms_d   = ms_q;
    tc_d   = tc_q;
    seen_d = seen_q;
    to_d   = to_q;
    case (st_q)
      BU_SETTLE: if (tick) begin
        if (ms_q == SETTLE_LAST) begin
          st_d = BU_PERST;
          ms_d = '0;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
      BU_PERST: if (tick) begin
        if (ms_q == PERST_LAST) begin
          st_d = BU_TRAIN;
          ms_d = '0;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
      BU_TRAIN: begin
        if (link_up) begin
          seen_d = 1'b1;
        end else if (!seen_q && !to_q && tick) begin
          if (tc_q == TO_LAST) to_d = 1'b1;
          else                 tc_d = tc_q + 1'b1;
        end
      end
      default: st_d = BU_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BU_SETTLE;
      ms_q   <= '0;
      tc_q   <= '0;
      seen_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ms_q   <= ms_d;
      tc_q   <= tc_d;
      seen_q <= seen_d;
      to_q   <= to_d;
    end
  end

  assign ep_rst_release = (st_q != BU_SETTLE);
  assign train_en       = (st_q == BU_TRAIN);
  assign link_timeout   = to_q;

  // training never runs with the endpoint held in reset
  assert_train_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |-> ep_rst_release);
  // release is permanent once given
  assert_release_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ep_rst_release |=> ep_rst_release);
  // the timeout flag never clears without reset
  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_timeout |=> link_timeout);
  // a timeout can only appear during training
  assert_timeout_in_train_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_timeout) |-> train_en);
endmodule

// File: rtl/lhm_recover.sv
module lhm_recover
  import lhm_pkg::*;
#(
  parameter int CHECK_MS  = 2,
  parameter int PULSE_CYC = 16,
  parameter logic [STATE_W-1:0] LOCK_CODE = 6'h0D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic [STATE_W-1:0] ltssm,
  input  logic rx_valid,
  output logic stuck_evt,
  output logic ovrd_data,
  output logic ovrd_pll
);
  localparam int CW = $clog2(CHECK_MS + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] CHK_LAST = CW'(CHECK_MS - 1);
  localparam logic [PW-1:0] PUL_LAST = PW'(PULSE_CYC - 1);

  rc_state_e st_q, st_d;
  logic [CW-1:0] ms_q, ms_d;
  logic [PW-1:0] pc_q, pc_d;
  logic ev_q, ev_d;
  logic stuck_now;

  assign stuck_now = (ltssm == LOCK_CODE) && !rx_valid;

  always_comb begin
    st_d = st_q;
    ms_d = ms_q;
    pc_d = pc_q;
    ev_d = 1'b0;
    case (st_q)
      RC_IDLE: if (start) begin
        st_d = RC_WAIT;
        ms_d = '0;
      end
      RC_WAIT: if (tick) begin
        if (ms_q == CHK_LAST) begin
          if (stuck_now) begin
            st_d = RC_PULSE;
            pc_d = '0;
            ev_d = 1'b1;
          end else begin
            st_d = RC_IDLE;
          end
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
      RC_PULSE: begin
        if (pc_q == PUL_LAST) st_d = RC_IDLE;
        else                  pc_d = pc_q + 1'b1;
      end
      default: st_d = RC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RC_IDLE;
      ms_q <= '0;
      pc_q <= '0;
      ev_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ms_q <= ms_d;
      pc_q <= pc_d;
      ev_q <= ev_d;
    end
  end

  assign stuck_evt = ev_q;
  assign ovrd_data = (st_q == RC_PULSE);
  assign ovrd_pll  = (st_q == RC_PULSE);

  // an override pulse begins only together with a detection event
  assert_pulse_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovrd_data) |-> stuck_evt);
  // the event is a single-cycle pulse
  assert_event_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_evt |=> !stuck_evt);
  // an event is always accompanied by the override
  assert_event_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_evt |-> (ovrd_data && ovrd_pll));
  // a start during a pulse does not cut it short: pulse counter keeps advancing
  assert_pulse_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RC_PULSE && pc_q != PUL_LAST) |=> (st_q == RC_PULSE));
endmodule

// File: rtl/link_health_ctrl.sv
module link_health_ctrl
  import lhm_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int SETTLE_MS  = 30,
  parameter int PERST_MS   = 20,
  parameter int TIMEOUT_MS = 100,
  parameter int CHECK_MS   = 2,
  parameter int PULSE_CYC  = 16,
  parameter logic [5:0] LOCK_CODE = 6'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dbg_word0,
  input  logic [31:0] dbg_word1,
  input  logic        rx_valid,
  input  logic        rate_chg_start,
  output logic        ep_rst_release,
  output logic        train_en,
  output logic        link_up,
  output logic        stuck_evt,
  output logic        ovrd_rx_data_en,
  output logic        ovrd_rx_pll_en,
  output logic        link_timeout
);
  logic tick;
  logic link_d, link_q;
  logic unused_dbg;

  assign unused_dbg = ^{dbg_word0[31:STATE_W], dbg_word1[31:TRAIN_BIT+1],
                        dbg_word1[TRAIN_BIT-1:UP_BIT+1], dbg_word1[UP_BIT-1:0]};

  lhm_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign link_d = dbg_word1[UP_BIT] && !dbg_word1[TRAIN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_d;
  end
  assign link_up = link_q;

  lhm_bringup #(
    .SETTLE_MS(SETTLE_MS), .PERST_MS(PERST_MS), .TIMEOUT_MS(TIMEOUT_MS)
  ) u_bringup (
    .clk(clk), .rst_n(rst_n), .tick(tick), .link_up(link_q),
    .ep_rst_release(ep_rst_release), .train_en(train_en),
    .link_timeout(link_timeout)
  );

  lhm_recover #(
    .CHECK_MS(CHECK_MS), .PULSE_CYC(PULSE_CYC), .LOCK_CODE(LOCK_CODE)
  ) u_recover (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(rate_chg_start),
    .ltssm(dbg_word0[STATE_W-1:0]), .rx_valid(rx_valid),
    .stuck_evt(stuck_evt), .ovrd_data(ovrd_rx_data_en), .ovrd_pll(ovrd_rx_pll_en)
  );

  // the in-training bit always masks the up indication
  assert_train_masks_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_word1[TRAIN_BIT] |=> !link_up);
  // both override enables move as a pair
  assert_override_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovrd_rx_data_en == ovrd_rx_pll_en);
endmodule

// File: tb/test_link_health_ctrl.sv
module test_link_health_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CPM   = 10;
  localparam int SET_MS = 3;
  localparam int PER_MS = 2;
  localparam int TO_MS  = 20;
  localparam int CHK_MS = 2;
  localparam int PUL    = 4;
  localparam int CODE   = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] dbg0, dbg1;
  logic rxv, start;
  logic ep_rel, tren, lup, sevt, ovd, ovp, tout;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ov_cycles = 0, ov_rises = 0, ev_cnt = 0;
  logic ov_prev = 1'b0;

  // reference model state
  int m_pre, m_ph, m_ms, m_tc, m_rs, m_rms, m_rpc;
  bit m_link, m_seen, m_to, m_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_health_ctrl #(
    .CYC_PER_MS(CPM), .SETTLE_MS(SET_MS), .PERST_MS(PER_MS),
    .TIMEOUT_MS(TO_MS), .CHECK_MS(CHK_MS), .PULSE_CYC(PUL), .LOCK_CODE(6'(CODE))
  ) i_link_health_ctrl (
    .clk(clk), .rst_n(rst_n), .dbg_word0(dbg0), .dbg_word1(dbg1),
    .rx_valid(rxv), .rate_chg_start(start),
    .ep_rst_release(ep_rel), .train_en(tren), .link_up(lup),
    .stuck_evt(sevt), .ovrd_rx_data_en(ovd), .ovrd_rx_pll_en(ovp),
    .link_timeout(tout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference, evaluated on the same edge the design uses
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_ph = 0; m_ms = 0; m_tc = 0; m_rs = 0; m_rms = 0; m_rpc = 0;
      m_link = 0; m_seen = 0; m_to = 0; m_ev = 0;
    end else begin
      bit tk, old_link;
      tk = (m_pre == CPM - 1);
      m_pre = tk ? 0 : m_pre + 1;
      old_link = m_link;
      m_link = dbg1[4] && !dbg1[29];
      if (m_ph == 0 && tk) begin
        if (m_ms == SET_MS - 1) begin m_ph = 1; m_ms = 0; end else m_ms++;
      end else if (m_ph == 1 && tk) begin
        if (m_ms == PER_MS - 1) begin m_ph = 2; m_ms = 0; end else m_ms++;
      end else if (m_ph == 2) begin
        if (old_link) m_seen = 1;
        else if (!m_seen && !m_to && tk) begin
          if (m_tc == TO_MS - 1) m_to = 1; else m_tc++;
        end
      end
      m_ev = 0;
      if (m_rs == 0) begin
        if (start) begin m_rs = 1; m_rms = 0; end
      end else if (m_rs == 1) begin
        if (tk) begin
          if (m_rms == CHK_MS - 1) begin
            if ((dbg0 % 64) == CODE && !rxv) begin m_rs = 2; m_rpc = 0; m_ev = 1; end
            else m_rs = 0;
          end else m_rms++;
        end
      end else begin
        if (m_rpc == PUL - 1) m_rs = 0; else m_rpc++;
      end
    end
  end

  // per-cycle comparison and pulse bookkeeping, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2", ep_rel, m_ph != 0);
      chk("R3", tren, m_ph == 2);
      chk("R4", lup, m_link);
      chk("R5", sevt, m_ev);
      chk("R6", {ovd, ovp}, {2{m_rs == 2}});
      chk("R9", tout, m_to);
      if (ovd) ov_cycles++;
      if (ovd && !ov_prev) ov_rises++;
      if (sevt) ev_cnt++;
      ov_prev = ovd;
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clr_counts();
    ov_cycles = 0; ov_rises = 0; ev_cnt = 0;
  endtask

  task automatic attempt();
    start = 1'b1;
    cycles(1);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; dbg0 = '0; dbg1 = '0; rxv = 1'b0; start = 1'b0;
    cycles(3);
    // R1: everything low under reset
    chk("R1", {ep_rel, tren, lup, sevt, ovd, ovp, tout}, 7'b0);
    rst_n = 1'b1;

    // no link ever: timeout after bring-up plus window
    cycles(320);
    chk("R3", tren, 1'b1);
    chk("R9", tout, 1'b1);
    // up bit together with in-training bit must not count as up
    dbg1 = (32'h1 << 4) | (32'h1 << 29);
    cycles(5);
    chk("R4", lup, 1'b0);
    dbg1 = 32'h1 << 4;
    cycles(3);
    chk("R4", lup, 1'b1);
    chk("R9", tout, 1'b1);

    // fresh bring-up with link reported early: no timeout
    @(negedge clk); rst_n = 1'b0;
    cycles(2);
    chk("R1", {ep_rel, tren, tout}, 3'b0);
    rst_n = 1'b1;
    cycles(15);
    chk("R2", ep_rel, 1'b0);
    cycles(320);
    chk("R9", tout, 1'b0);
    chk("R4", lup, 1'b1);

    // stuck in receiver lock, with a second start during the wait
    dbg0 = 32'h0000_000D; rxv = 1'b0; clr_counts();
    attempt();
    cycles(8);
    attempt();
    cycles(60);
    chk("R6", ov_cycles, PUL);
    chk("R8", ov_rises, 1);
    chk("R5", ev_cnt, 1);

    // receive valid present: nothing happens
    rxv = 1'b1; clr_counts();
    attempt();
    cycles(60);
    chk("R7", ov_cycles, 0);
    chk("R7", ev_cnt, 0);

    // different state code: nothing happens
    rxv = 1'b0; dbg0 = 32'h0000_000E; clr_counts();
    attempt();
    cycles(60);
    chk("R7", ov_rises, 0);

    // upper bits set, low six bits hold the lock code: pulse
    dbg0 = 32'hFFFF_FFCD; clr_counts();
    attempt();
    cycles(60);
    chk("R5", ev_cnt, 1);
    chk("R6", ov_cycles, PUL);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule